// File: doc/BRIEF.md
# Decimal Address Relocation and Bounds Check

This block forms absolute memory addresses for a decimal machine. A five-digit BCD address, relative to the running program, is added to a three-digit BCD base register placed at the thousands position. If the request asks for it, a signed six-digit index value is then added or subtracted. The result is a six-digit BCD absolute address, wrapped modulo one million. The three high-order digits of that result are then compared with the base register, which is the lower bound, and with a limit register, which is the upper bound. An address outside those bounds raises a protection-violation flag.

Requests arrive on a valid/ready stream. Results leave on a second valid/ready stream through one output register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_ready` is held low, a pending result stays on the outputs unchanged, and no new request is taken.

Base and limit are plain control state. A load strobe restores both registers from values that the supervisor has kept. A supervisor-entry strobe clears the base to zero and opens the limit to the memory-size parameter. During the strobe cycle the `cur_base` and `cur_limit` outputs still show the old values, so they can be saved.

Top module: `dec_reloc`

## Requirements
- R1: The absolute address equals the relative address plus the base value times 1000, written as six BCD digits.
- R2: Index word layout, from the most significant nibble down:
  - nibble 7 ([31:28]) is the sign; the value 0xD means negative and any other value means positive;
  - nibble 6 ([27:24]) is ignored;
  - nibbles 5..0 ([23:0]) hold the six-digit magnitude.
  When indexing is enabled, the signed value is added to the relocated sum and the result is taken modulo 10^6.
- R3: When indexing is disabled, the index word has no effect on any output.
- R4: The result is legal when base <= top three digits <= limit, with both bounds inclusive. Any other result sets `out_viol`.
- R5: `out_err` is set, and it forces `out_viol`, in any of these cases:
  - a relative-address digit is above 9;
  - indexing is enabled and an index-magnitude digit is above 9;
  - a base or limit register digit is above 9.
- R6: A cycle with `ld_stb` high, and `enter_stb` low, loads `ld_base` and `ld_limit` into the registers. The new values show on `cur_base` and `cur_limit` after that edge.
- R7: After an edge with `enter_stb` high, the base reads 000 and the limit reads MEM_TOP. During the strobe cycle the old values stay visible. `enter_stb` wins over `ld_stb` when both are high.
- R8: A result appears on `out_valid` one cycle after its request is accepted. The result is held stable while `out_ready` is low. `in_ready` is high exactly when the output register is empty or `out_ready` is high.
- R9: After reset the base is 000, the limit is MEM_TOP and `out_valid` is low.
- R10: Relocation and the bounds check use the register values in force before the acceptance edge. They do not use values loaded or cleared on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_rel | input | 20 | Five-digit BCD relative address |
| in_idx_en | input | 1 | Apply the index word |
| in_idx | input | 32 | Index word: sign nibble, ignored nibble, six-digit magnitude |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_abs | output | 24 | Six-digit BCD absolute address |
| out_viol | output | 1 | Protection violation |
| out_err | output | 1 | Non-decimal digit seen |
| ld_stb | input | 1 | Restore base and limit |
| ld_base | input | 12 | Base value to restore |
| ld_limit | input | 12 | Limit value to restore |
| enter_stb | input | 1 | Supervisor entry: clear base, open limit |
| cur_base | output | 12 | Current base register |
| cur_limit | output | 12 | Current limit register |

## Verification
The bench keeps the default digit counts: five relative digits, a three-digit base and a six-digit absolute address. It sets MEM_TOP to 199 so that the limit after supervisor entry is small. With that limit, results that wrap below zero land at 999xxx and cross the upper bound. Base and limit are restored to 137 and 150 so that single-digit steps in the index land exactly on each inclusive bound and one past it.

// File: rtl/dec_reloc_pkg.sv
package dec_reloc_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t SIGN_NEG = 4'hD;

  function automatic logic digit_ok(input bcd_t d);
    return d <= 4'd9;
  endfunction

  function automatic bcd_t nine_comp(input bcd_t d);
    return 4'd9 - d;
  endfunction
endpackage

// File: rtl/dec_digit_add.sv
module dec_digit_add (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] s,
  output logic       cout
);
  logic [4:0] raw;
  assign raw  = {1'b0, a} + {1'b0, b} + {4'b0, cin};
  assign cout = raw > 5'd9;
  assign s    = cout ? raw[3:0] + 4'd6 : raw[3:0];
endmodule

// File: rtl/dec_add_chain.sv
module dec_add_chain #(
  parameter int DIGITS = 6
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  input  logic                cin,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  logic [DIGITS:0] carry;
  assign carry[0] = cin;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    dec_digit_add u_d (
      .a   (a[4*g +: 4]),
      .b   (b[4*g +: 4]),
      .cin (carry[g]),
      .s   (sum[4*g +: 4]),
      .cout(carry[g+1])
    );
  end
  assign cout = carry[DIGITS];
endmodule

// File: rtl/dec_reloc.sv
module dec_reloc
  import dec_reloc_pkg::*;
#(
  parameter int          REL_DIGITS  = 5,
  parameter int          BASE_DIGITS = 3,
  parameter logic [11:0] MEM_TOP     = 12'h999
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [4*REL_DIGITS-1:0]        in_rel,
  input  logic                           in_idx_en,
  input  logic [4*(REL_DIGITS+3)-1:0]    in_idx,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [4*(REL_DIGITS+1)-1:0]    out_abs,
  output logic                           out_viol,
  output logic                           out_err,
  input  logic                           ld_stb,
  input  logic [4*BASE_DIGITS-1:0]       ld_base,
  input  logic [4*BASE_DIGITS-1:0]       ld_limit,
  input  logic                           enter_stb,
  output logic [4*BASE_DIGITS-1:0]       cur_base,
  output logic [4*BASE_DIGITS-1:0]       cur_limit
);
  localparam int ABS_DIGITS = REL_DIGITS + 1;
  localparam int SHIFT      = ABS_DIGITS - BASE_DIGITS;
  localparam int PAD        = ABS_DIGITS - REL_DIGITS;
  localparam int IXW_DIGITS = ABS_DIGITS + 2;
  localparam int AW         = 4 * ABS_DIGITS;
  localparam int BW         = 4 * BASE_DIGITS;
  localparam logic [BW-1:0] LIMIT_OPEN = BW'(MEM_TOP);

  // base / limit registers
  logic [BW-1:0] base_q, limit_q;
  always_ff @(posedge clk) begin
    if (!rst_n || enter_stb) begin
      base_q  <= '0;
      limit_q <= LIMIT_OPEN;
    end else if (ld_stb) begin
      base_q  <= ld_base;
      limit_q <= ld_limit;
    end
  end
  assign cur_base  = base_q;
  assign cur_limit = limit_q;

  // index decode
  logic [AW-1:0] mag, idx_term;
  logic          neg;
  assign mag = in_idx[AW-1:0];
  assign neg = in_idx[4*IXW_DIGITS-1 -: 4] == SIGN_NEG;
  for (genvar g = 0; g < ABS_DIGITS; g++) begin : g_idx
    assign idx_term[4*g +: 4] = !in_idx_en ? 4'd0 :
                                neg ? nine_comp(mag[4*g +: 4]) : mag[4*g +: 4];
  end

  // relocation: rel + base*10^SHIFT, then +/- index (mod 10^ABS_DIGITS)
  logic [AW-1:0] op_rel, op_base, reloc_sum, abs_sum;
  logic          add1_cout_unused, add2_cout_unused;
  assign op_rel  = {{(4*PAD){1'b0}}, in_rel};
  assign op_base = {base_q, {(4*SHIFT){1'b0}}};

  dec_add_chain #(.DIGITS(ABS_DIGITS)) u_reloc (
    .a(op_rel), .b(op_base), .cin(1'b0), .sum(reloc_sum), .cout(add1_cout_unused)
  );
  dec_add_chain #(.DIGITS(ABS_DIGITS)) u_index (
    .a(reloc_sum), .b(idx_term), .cin(in_idx_en & neg), .sum(abs_sum), .cout(add2_cout_unused)
  );

  // non-decimal digit detection
  logic [REL_DIGITS-1:0]  rel_bad;
  logic [ABS_DIGITS-1:0]  mag_bad;
  logic [BASE_DIGITS-1:0] reg_bad;
  for (genvar g = 0; g < REL_DIGITS; g++) begin : g_rbad
    assign rel_bad[g] = !digit_ok(in_rel[4*g +: 4]);
  end
  for (genvar g = 0; g < ABS_DIGITS; g++) begin : g_mbad
    assign mag_bad[g] = in_idx_en && !digit_ok(mag[4*g +: 4]);
  end
  for (genvar g = 0; g < BASE_DIGITS; g++) begin : g_gbad
    assign reg_bad[g] = !digit_ok(base_q[4*g +: 4]) || !digit_ok(limit_q[4*g +: 4]);
  end

  logic          err_c, viol_c;
  logic [BW-1:0] top;
  assign err_c  = |{rel_bad, mag_bad, reg_bad};
  assign top    = abs_sum[AW-1 -: BW];
  assign viol_c = err_c || (top < base_q) || (top > limit_q);

  // output register with valid/ready
  assign in_ready = !out_valid || out_ready;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_abs   <= '0;
      out_viol  <= 1'b0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_abs  <= abs_sum;
        out_viol <= viol_c;
        out_err  <= err_c;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{add1_cout_unused, add2_cout_unused, in_idx[4*IXW_DIGITS-5 -: 4]};
endmodule

// File: rtl/dec_reloc_chk.sv
module dec_reloc_chk #(
  parameter int          AW      = 24,
  parameter int          BW      = 12,
  parameter logic [11:0] MEM_TOP = 12'h999
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_abs,
  input logic          out_viol,
  input logic          out_err,
  input logic          ld_stb,
  input logic [BW-1:0] ld_base,
  input logic [BW-1:0] ld_limit,
  input logic          enter_stb,
  input logic [BW-1:0] cur_base,
  input logic [BW-1:0] cur_limit
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_abs) && $stable(out_viol) && $stable(out_err));

  assert_err_viol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_viol);

  assert_entry_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stb |=> cur_base == '0 && cur_limit == BW'(MEM_TOP));

  assert_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb && !enter_stb |=> cur_base == $past(ld_base) && cur_limit == $past(ld_limit));

  assert_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_viol ||
      (out_abs[AW-1 -: BW] >= $past(cur_base) && out_abs[AW-1 -: BW] <= $past(cur_limit)));
endmodule

bind dec_reloc dec_reloc_chk #(
  .AW(4*(REL_DIGITS+1)), .BW(4*BASE_DIGITS), .MEM_TOP(MEM_TOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_abs(out_abs),
  .out_viol(out_viol), .out_err(out_err), .ld_stb(ld_stb), .ld_base(ld_base),
  .ld_limit(ld_limit), .enter_stb(enter_stb), .cur_base(cur_base), .cur_limit(cur_limit)
);

// File: tb/sim_dec_reloc.sv
`timescale 1ns/1ps
module sim_dec_reloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [19:0] in_rel = '0;
  logic        in_idx_en = 1'b0;
  logic [31:0] in_idx = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [23:0] out_abs;
  logic        out_viol, out_err;
  logic        ld_stb = 1'b0, enter_stb = 1'b0;
  logic [11:0] ld_base = '0, ld_limit = '0;
  logic [11:0] cur_base, cur_limit;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dec_reloc #(.MEM_TOP(12'h199)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rel(in_rel), .in_idx_en(in_idx_en), .in_idx(in_idx),
    .out_valid(out_valid), .out_ready(out_ready), .out_abs(out_abs),
    .out_viol(out_viol), .out_err(out_err), .ld_stb(ld_stb), .ld_base(ld_base),
    .ld_limit(ld_limit), .enter_stb(enter_stb), .cur_base(cur_base), .cur_limit(cur_limit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int bcd2int(input logic [31:0] v, input int nd);
    int r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [23:0] int2bcd(input int v);
    logic [23:0] r;
    for (int i = 0; i < 6; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  // model from requirements; b and l are the base/limit in force
  task automatic req(input string tag, input logic [19:0] rel, input logic en,
                     input logic [31:0] idx, input int b, input int l);
    int r, top;
    logic err;
    err = 1'b0;
    for (int i = 0; i < 5; i++) if (rel[4*i +: 4] > 4'd9) err = 1'b1;
    if (en) for (int i = 0; i < 6; i++) if (idx[4*i +: 4] > 4'd9) err = 1'b1;
    r = bcd2int({12'h0, rel}, 5) + b * 1000;
    if (en) begin
      if (idx[31:28] == 4'hD) r = r - bcd2int({8'h0, idx[23:0]}, 6);
      else                    r = r + bcd2int({8'h0, idx[23:0]}, 6);
    end
    r = (r + 1000000) % 1000000;
    top = r / 1000;
    @(negedge clk);
    in_rel = rel; in_idx_en = en; in_idx = idx; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    if (!err) check({tag, " abs"}, {8'b0, out_abs}, {8'b0, int2bcd(r)});
    check({tag, " err"}, {31'b0, out_err}, {31'b0, err});
    check({tag, " viol"}, {31'b0, out_viol}, {31'b0, err || top < b || top > l});
  endtask

  task automatic restore(input logic [11:0] b, input logic [11:0] l);
    @(negedge clk);
    ld_base = b; ld_limit = l; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    check("R6 base", {20'b0, cur_base}, {20'b0, b});
    check("R6 limit", {20'b0, cur_limit}, {20'b0, l});
  endtask

  task automatic t_reset;
    check("R9 out_valid", {31'b0, out_valid}, 32'd0);
    check("R8 in_ready", {31'b0, in_ready}, 32'd1);
    check("R9 base", {20'b0, cur_base}, 32'h000);
    check("R9 limit", {20'b0, cur_limit}, 32'h199);
  endtask

  task automatic t_reloc_index;
    restore(12'h137, 12'h150);
    req("R1 plain", 20'h12345, 1'b0, 32'h0, 137, 150);
    req("R2 R4 pos upper", 20'h12345, 1'b1, 32'hC0000700, 137, 150);
    req("R4 over upper", 20'h12345, 1'b1, 32'h00002000, 137, 150);
    req("R2 R4 neg lower", 20'h12345, 1'b1, 32'hD0012345, 137, 150);
    req("R4 under lower", 20'h12345, 1'b1, 32'hD0012346, 137, 150);
    req("R2 digit2 ignored", 20'h12345, 1'b1, 32'h0F000001, 137, 150);
    req("R3 index off", 20'h12345, 1'b0, 32'hDFFFFFFF, 137, 150);
    restore(12'h000, 12'h199);
    req("R2 wrap", 20'h00005, 1'b1, 32'hD0000010, 0, 199);
  endtask

  task automatic t_digit_err;
    req("R5 rel digit", 20'h1A345, 1'b0, 32'h0, 0, 199);
    req("R5 index digit", 20'h00100, 1'b1, 32'h000000A0, 0, 199);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_rel = 20'h00042; in_idx_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_rel = 20'h00077;
    check("R8 first valid", {31'b0, out_valid}, 32'd1);
    check("R8 stall ready", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    check("R8 held", {8'b0, out_abs}, 32'h000042);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second", {8'b0, out_abs}, 32'h000077);
    check("R8 second valid", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R8 drained", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_enter;
    restore(12'h137, 12'h150);
    @(negedge clk);
    enter_stb = 1'b1; ld_stb = 1'b1; ld_base = 12'h500; ld_limit = 12'h600;
    in_rel = 20'h13000; in_idx_en = 1'b0; in_valid = 1'b1;
    #1;
    check("R7 old base visible", {20'b0, cur_base}, 32'h137);
    check("R7 old limit visible", {20'b0, cur_limit}, 32'h150);
    @(negedge clk);
    enter_stb = 1'b0; ld_stb = 1'b0; in_valid = 1'b0;
    check("R7 base cleared", {20'b0, cur_base}, 32'h000);
    check("R7 limit open", {20'b0, cur_limit}, 32'h199);
    check("R10 old base used", {8'b0, out_abs}, 32'h150000);
    check("R10 old bounds", {31'b0, out_viol}, 32'd0);
    req("R1 after entry", 20'h12345, 1'b0, 32'h0, 0, 199);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_reloc_index;
    t_digit_err;
    t_backpressure;
    t_enter;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule